// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block holds the results of instructions that execute out of order and releases them to architectural state strictly in program order. The issue stage allocates an entry and receives its index, which serves as the result tag. A functional unit later writes its result under that tag, together with a mispredict flag and an exception flag. Results may arrive in any order. Only the oldest entry may retire, and only once its result is present.

When the oldest entry is ready, the block does one of two things. It either releases a register write or a memory write on the commit outputs, or it discards every outstanding entry and raises a redirect strobe. It discards on a branch that was marked mispredicted or on an entry that carries an exception. Flags on younger entries have no effect until those entries become oldest. A read port lets reservation stations pick up a completed result by its tag before that result retires.

Top module: `rob_core`

## Requirements
- R1: After reset the first allocation receives tag 0. Each accepted allocation receives the next tag, modulo DEPTH. An allocation accepted in the same cycle as a retirement also advances the tag.
- R2: `alloc_ready_o` is low when DEPTH entries are outstanding, and an allocation request in that state is not accepted.
- R3: A completion may target any outstanding tag in any order. From the next cycle, the read port reports that tag as ready and returns the value.
- R4: A completion to a tag that holds no outstanding entry is ignored, and the read port keeps reporting that tag as not ready.
- R5: Only the oldest entry can retire, and at most one entry retires per cycle. A completed younger entry waits while the oldest entry is not ready.
- R6: Entry kinds are encoded as 2'b00 register write, 2'b01 store, 2'b10 branch and 2'b11 no-op. When the oldest entry is ready and carries neither fault, `retire_o` pulses in that cycle. A register entry also drives `reg_we_o` with its destination and value, and a store entry drives `mem_we_o` with its address and value.
- R7: When the oldest entry is a ready branch marked mispredicted, `flush_o` pulses with no write. In the next cycle the buffer is empty, the next tag is 0, and all earlier tags read as not ready.
- R8: An exception flag takes effect only when its entry is oldest and ready. The block then raises `flush_o` and `excp_o` together, performs no write and empties the buffer.
- R9: A mispredict flag on an entry that is not a branch is ignored, and the entry retires normally.
- R10: In a flush cycle `alloc_ready_o` is low, and allocation requests and completions in that cycle have no effect.
- R11: During reset `alloc_ready_o` is high, `alloc_tag_o` is 0, and `retire_o` and `flush_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocation request |
| alloc_kind_i | input | 2 | Entry kind of the new entry |
| alloc_dest_i | input | DEST_W | Destination register or store address |
| alloc_ready_o | output | 1 | Allocation accepted this cycle if requested |
| alloc_tag_o | output | log2(DEPTH) | Tag given to the next allocation |
| cmpl_valid_i | input | 1 | Completion strobe |
| cmpl_tag_i | input | log2(DEPTH) | Tag being completed |
| cmpl_value_i | input | DATA_W | Result value |
| cmpl_mispred_i | input | 1 | Branch was mispredicted |
| cmpl_excp_i | input | 1 | Instruction raised an exception |
| rd_tag_i | input | log2(DEPTH) | Forwarding read tag |
| rd_ready_o | output | 1 | Read tag is outstanding and completed |
| rd_value_o | output | DATA_W | Value of read tag |
| retire_o | output | 1 | Oldest entry retires this cycle |
| reg_we_o | output | 1 | Register write on retirement |
| reg_dest_o | output | DEST_W | Register number |
| reg_data_o | output | DATA_W | Register value |
| mem_we_o | output | 1 | Memory write on retirement |
| mem_addr_o | output | DEST_W | Store address |
| mem_data_o | output | DATA_W | Store value |
| flush_o | output | 1 | Redirect strobe; all entries discarded |
| excp_o | output | 1 | Flush caused by an exception |

## Verification
The bench fills the buffer to capacity and then completes the tags in scrambled order. If the design confused full with empty, it would keep accepting allocations and overwrite live entries. If it let a younger completed entry retire, writes would leave early and out of order. A fault flag is placed on a younger entry to catch a design that raises it before the entry is oldest, and mispredict flags on register entries catch a design that flushes on them. The bench also requests allocations and completions during a flush cycle. A design that let these through would leave a stale entry behind, which shows up as a non-zero tag or a ready read after the flush.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10,
    KIND_NOP    = 2'b11
  } kind_e;

  typedef struct packed {
    logic  ready;
    logic  mispred;
    logic  excp;
    kind_e kind;
  } status_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic                     pop_i,
  input  logic                     clear_i,
  output logic [$clog2(DEPTH)-1:0] head_o,
  output logic [$clog2(DEPTH)-1:0] tail_o,
  output logic                     full_o,
  output logic                     empty_o
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, tail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (push_i) tail_q <= tail_q + PTR_W'(1);
      if (pop_i)  head_q <= head_q + PTR_W'(1);
    end
  end

  assign head_o  = head_q[IDX_W-1:0];
  assign tail_o  = tail_q[IDX_W-1:0];
  // same index, wrap bits tell full from empty
  assign empty_o = (head_q == tail_q);
  assign full_o  = (head_q[IDX_W-1:0] == tail_q[IDX_W-1:0]) &&
                   (head_q[IDX_W] != tail_q[IDX_W]);
endmodule

// File: rtl/rob_slots.sv
module rob_slots import rob_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     clear_i,
  input  logic                     alloc_en_i,
  input  logic [$clog2(DEPTH)-1:0] alloc_idx_i,
  input  kind_e                    alloc_kind_i,
  input  logic [DEST_W-1:0]        alloc_dest_i,
  input  logic                     cmpl_en_i,
  input  logic [$clog2(DEPTH)-1:0] cmpl_idx_i,
  input  logic [DATA_W-1:0]        cmpl_value_i,
  input  logic                     cmpl_mispred_i,
  input  logic                     cmpl_excp_i,
  input  logic                     retire_en_i,
  input  logic [$clog2(DEPTH)-1:0] head_idx_i,
  input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
  output logic                     head_valid_o,
  output status_t                  head_stat_o,
  output logic [DEST_W-1:0]        head_dest_o,
  output logic [DATA_W-1:0]        head_value_o,
  output logic                     rd_ready_o,
  output logic [DATA_W-1:0]        rd_value_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0]  valid_q;
  status_t           stat_q  [DEPTH];
  logic [DEST_W-1:0] dest_q  [DEPTH];
  logic [DATA_W-1:0] value_q [DEPTH];

  logic [DEPTH-1:0] alloc_hit, cmpl_hit, ret_hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    assign alloc_hit[g] = alloc_en_i  && (alloc_idx_i == IDX_W'(g));
    assign cmpl_hit[g]  = cmpl_en_i   && (cmpl_idx_i  == IDX_W'(g)) && valid_q[g];
    assign ret_hit[g]   = retire_en_i && (head_idx_i  == IDX_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        valid_q[i] <= 1'b0;
        stat_q[i]  <= '0;
        dest_q[i]  <= '0;
        value_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (clear_i) begin
          valid_q[i]      <= 1'b0;
          stat_q[i].ready <= 1'b0;
        end else begin
          if (alloc_hit[i]) begin
            valid_q[i] <= 1'b1;
            stat_q[i]  <= '{ready: 1'b0, mispred: 1'b0, excp: 1'b0, kind: alloc_kind_i};
            dest_q[i]  <= alloc_dest_i;
          end else if (cmpl_hit[i]) begin
            stat_q[i].ready   <= 1'b1;
            stat_q[i].mispred <= cmpl_mispred_i;
            stat_q[i].excp    <= cmpl_excp_i;
            value_q[i]        <= cmpl_value_i;
          end
          if (ret_hit[i]) valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign head_valid_o = valid_q[head_idx_i];
  assign head_stat_o  = stat_q[head_idx_i];
  assign head_dest_o  = dest_q[head_idx_i];
  assign head_value_o = value_q[head_idx_i];
  assign rd_ready_o   = valid_q[rd_idx_i] && stat_q[rd_idx_i].ready;
  assign rd_value_o   = value_q[rd_idx_i];
endmodule

// File: rtl/rob_retire.sv
module rob_retire import rob_pkg::*; (
  input  logic    empty_i,
  input  logic    head_valid_i,
  input  status_t head_stat_i,
  output logic    retire_o,
  output logic    reg_we_o,
  output logic    mem_we_o,
  output logic    flush_o,
  output logic    excp_o
);
  logic go, bad_branch;

  assign go         = !empty_i && head_valid_i && head_stat_i.ready;
  // mispredict only counts on branches
  assign bad_branch = (head_stat_i.kind == KIND_BRANCH) && head_stat_i.mispred;
  assign excp_o     = go && head_stat_i.excp;
  assign flush_o    = go && (head_stat_i.excp || bad_branch);
  assign retire_o   = go && !flush_o;
  assign reg_we_o   = retire_o && (head_stat_i.kind == KIND_REG);
  assign mem_we_o   = retire_o && (head_stat_i.kind == KIND_STORE);
endmodule

// File: rtl/rob_core.sv
module rob_core import rob_pkg::*; #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     alloc_valid_i,
  input  logic [1:0]               alloc_kind_i,
  input  logic [DEST_W-1:0]        alloc_dest_i,
  output logic                     alloc_ready_o,
  output logic [$clog2(DEPTH)-1:0] alloc_tag_o,
  input  logic                     cmpl_valid_i,
  input  logic [$clog2(DEPTH)-1:0] cmpl_tag_i,
  input  logic [DATA_W-1:0]        cmpl_value_i,
  input  logic                     cmpl_mispred_i,
  input  logic                     cmpl_excp_i,
  input  logic [$clog2(DEPTH)-1:0] rd_tag_i,
  output logic                     rd_ready_o,
  output logic [DATA_W-1:0]        rd_value_o,
  output logic                     retire_o,
  output logic                     reg_we_o,
  output logic [DEST_W-1:0]        reg_dest_o,
  output logic [DATA_W-1:0]        reg_data_o,
  output logic                     mem_we_o,
  output logic [DEST_W-1:0]        mem_addr_o,
  output logic [DATA_W-1:0]        mem_data_o,
  output logic                     flush_o,
  output logic                     excp_o
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full, empty, alloc_fire, cmpl_en;
  logic              head_valid;
  status_t           head_stat;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;

  assign alloc_ready_o = !full && !flush_o;
  assign alloc_fire    = alloc_valid_i && alloc_ready_o;
  assign cmpl_en       = cmpl_valid_i && !flush_o;
  assign alloc_tag_o   = tail_idx;

  rob_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (alloc_fire),
    .pop_i   (retire_o),
    .clear_i (flush_o),
    .head_o  (head_idx),
    .tail_o  (tail_idx),
    .full_o  (full),
    .empty_o (empty)
  );

  rob_slots #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W)) u_slots (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .clear_i        (flush_o),
    .alloc_en_i     (alloc_fire),
    .alloc_idx_i    (tail_idx),
    .alloc_kind_i   (kind_e'(alloc_kind_i)),
    .alloc_dest_i   (alloc_dest_i),
    .cmpl_en_i      (cmpl_en),
    .cmpl_idx_i     (cmpl_tag_i),
    .cmpl_value_i   (cmpl_value_i),
    .cmpl_mispred_i (cmpl_mispred_i),
    .cmpl_excp_i    (cmpl_excp_i),
    .retire_en_i    (retire_o),
    .head_idx_i     (head_idx),
    .rd_idx_i       (rd_tag_i),
    .head_valid_o   (head_valid),
    .head_stat_o    (head_stat),
    .head_dest_o    (head_dest),
    .head_value_o   (head_value),
    .rd_ready_o     (rd_ready_o),
    .rd_value_o     (rd_value_o)
  );

  rob_retire u_retire (
    .empty_i      (empty),
    .head_valid_i (head_valid),
    .head_stat_i  (head_stat),
    .retire_o     (retire_o),
    .reg_we_o     (reg_we_o),
    .mem_we_o     (mem_we_o),
    .flush_o      (flush_o),
    .excp_o       (excp_o)
  );

  assign reg_dest_o = head_dest;
  assign reg_data_o = head_value;
  assign mem_addr_o = head_dest;
  assign mem_data_o = head_value;
endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
  parameter int DEPTH = 8
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     alloc_valid_i,
  input logic                     alloc_ready_o,
  input logic [$clog2(DEPTH)-1:0] alloc_tag_o,
  input logic                     retire_o,
  input logic                     reg_we_o,
  input logic                     mem_we_o,
  input logic                     flush_o,
  input logic                     excp_o
);
  localparam int TAG_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  logic [OCC_W-1:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else if (flush_o) occ_q <= '0;
    else occ_q <= occ_q + OCC_W'(alloc_valid_i && alloc_ready_o) - OCC_W'(retire_o);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == OCC_W'(DEPTH)) |-> !alloc_ready_o); // R2
  AST_EMPTY_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_q == '0) |-> !(retire_o || flush_o)); // R5
  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o || mem_we_o) |-> (retire_o && !(reg_we_o && mem_we_o))); // R6
  AST_FLUSH_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (!reg_we_o && !mem_we_o && !retire_o && !alloc_ready_o)); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (alloc_tag_o == '0 && !retire_o && !flush_o)); // R7
  AST_EXCP_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    excp_o |-> flush_o); // R8
  AST_TAG_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && alloc_ready_o) |=> (alloc_tag_o == $past(alloc_tag_o) + TAG_W'(1))); // R1
endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        a_v, c_v, c_mp, c_ex;
  logic [1:0]  a_kind;
  logic [4:0]  a_dest;
  logic [2:0]  c_tag, rd_tag;
  logic [31:0] c_val;
  logic        alloc_ready_o, rd_ready_o, retire_o, reg_we_o, mem_we_o, flush_o, excp_o;
  logic [2:0]  alloc_tag_o;
  logic [31:0] rd_value_o, reg_data_o, mem_data_o;
  logic [4:0]  reg_dest_o, mem_addr_o;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  rob_core u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .alloc_valid_i(a_v), .alloc_kind_i(a_kind), .alloc_dest_i(a_dest),
    .alloc_ready_o(alloc_ready_o), .alloc_tag_o(alloc_tag_o),
    .cmpl_valid_i(c_v), .cmpl_tag_i(c_tag), .cmpl_value_i(c_val),
    .cmpl_mispred_i(c_mp), .cmpl_excp_i(c_ex),
    .rd_tag_i(rd_tag), .rd_ready_o(rd_ready_o), .rd_value_o(rd_value_o),
    .retire_o(retire_o), .reg_we_o(reg_we_o), .reg_dest_o(reg_dest_o), .reg_data_o(reg_data_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o),
    .flush_o(flush_o), .excp_o(excp_o)
  );

  typedef struct {
    int          tag;
    int          kind;
    int          dest;
    bit          rdy;
    logic [31:0] val;
    bit          mp;
    bit          ex;
  } ent_t;

  ent_t q[$];
  int   tail_cnt = 0;
  bit   m_flush, m_excp, m_retire, m_reg, m_mem, m_aready, m_rd;
  logic [31:0] m_rdv;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    a_v = 1'b0; a_kind = 2'b00; a_dest = '0;
    c_v = 1'b0; c_tag = '0; c_val = '0; c_mp = 1'b0; c_ex = 1'b0;
  endtask

  task automatic eval();
    m_flush = 0; m_excp = 0; m_retire = 0; m_reg = 0; m_mem = 0; m_rd = 0; m_rdv = '0;
    if (q.size() > 0 && q[0].rdy) begin
      if (q[0].ex) begin m_flush = 1; m_excp = 1; end
      else if (q[0].kind == 2 && q[0].mp) m_flush = 1;
      else begin
        m_retire = 1;
        m_reg = (q[0].kind == 0);
        m_mem = (q[0].kind == 1);
      end
    end
    m_aready = (q.size() < DEPTH) && !m_flush;
    foreach (q[i]) if (q[i].tag == int'(rd_tag) && q[i].rdy) begin m_rd = 1; m_rdv = q[i].val; end
  endtask

  task automatic compare();
    chk("R2 alloc_ready", 32'(alloc_ready_o), 32'(m_aready));
    chk("R1 alloc_tag", 32'(alloc_tag_o), 32'(tail_cnt));
    chk("R5 retire", 32'(retire_o), 32'(m_retire));
    chk("R6 reg_we", 32'(reg_we_o), 32'(m_reg));
    chk("R6 mem_we", 32'(mem_we_o), 32'(m_mem));
    chk("R7 flush", 32'(flush_o), 32'(m_flush));
    chk("R8 excp", 32'(excp_o), 32'(m_excp));
    if (m_reg) begin
      chk("R6 reg_dest", 32'(reg_dest_o), 32'(q[0].dest));
      chk("R6 reg_data", reg_data_o, q[0].val);
    end
    if (m_mem) begin
      chk("R6 mem_addr", 32'(mem_addr_o), 32'(q[0].dest));
      chk("R6 mem_data", mem_data_o, q[0].val);
    end
    chk("R3 rd_ready", 32'(rd_ready_o), 32'(m_rd));
    if (m_rd) chk("R3 rd_value", rd_value_o, m_rdv);
  endtask

  task automatic model_update();
    if (m_flush) begin
      q.delete();
      tail_cnt = 0;
    end else begin
      if (c_v) foreach (q[i]) if (q[i].tag == int'(c_tag)) begin
        q[i].rdy = 1; q[i].val = c_val; q[i].mp = c_mp; q[i].ex = c_ex;
      end
      if (m_retire) void'(q.pop_front());
      if (a_v && m_aready) begin
        q.push_back('{tag: tail_cnt, kind: int'(a_kind), dest: int'(a_dest),
                      rdy: 1'b0, val: 32'h0, mp: 1'b0, ex: 1'b0});
        tail_cnt = (tail_cnt + 1) % DEPTH;
      end
    end
  endtask

  task automatic step();
    #1;
    eval();
    compare();
    @(posedge clk);
    model_update();
    @(negedge clk);
  endtask

  task automatic drain();
    for (int n = 0; n < 100 && q.size() > 0; n++) begin
      idle();
      foreach (q[i]) if (!q[i].rdy && !c_v) begin
        c_v = 1'b1; c_tag = 3'(q[i].tag); c_val = $urandom;
      end
      step();
    end
    idle();
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int ta;
    idle();
    rd_tag = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 alloc_ready in reset", 32'(alloc_ready_o), 32'd1);
    chk("R11 alloc_tag in reset", 32'(alloc_tag_o), 32'd0);
    chk("R11 retire in reset", 32'(retire_o), 32'd0);
    chk("R11 flush in reset", 32'(flush_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 fill to capacity with mixed kinds
    for (int i = 0; i < DEPTH; i++) begin
      idle(); a_v = 1'b1; a_kind = 2'(i % 3); a_dest = 5'(i + 1);
      step();
    end
    idle(); a_v = 1'b1; a_dest = 5'd31;
    step();
    chk("R2 full refuses allocation", 32'(alloc_tag_o), 32'd0);

    // R3 out-of-order completion, R5 head blocks younger
    idle(); c_v = 1'b1; c_tag = 3'd3; c_val = 32'hA3;
    step();
    idle(); rd_tag = 3'd3;
    step();
    chk("R3 forward completed tag", 32'(rd_ready_o), 32'd1);
    chk("R5 younger entry waits", 32'(retire_o), 32'd0);
    foreach (q[i]) begin
      if (!q[i].rdy && q[i].tag != 0) begin
        idle(); c_v = 1'b1; c_tag = 3'(q[i].tag); c_val = 32'h100 + 32'(q[i].tag);
        step();
      end
    end
    chk("R5 head still blocks", 32'(retire_o), 32'd0);
    drain();

    // R4 completion to empty slot is ignored
    idle(); c_v = 1'b1; c_tag = 3'd5; c_val = 32'hDEAD;
    step();
    idle(); rd_tag = 3'd5;
    step();
    chk("R4 stray completion ignored", 32'(rd_ready_o), 32'd0);

    // R7 mispredicted branch discards younger entry; R10 flush-cycle inputs ignored
    ta = tail_cnt;
    idle(); a_v = 1'b1; a_kind = 2'b00; a_dest = 5'd9;  step();
    idle(); a_v = 1'b1; a_kind = 2'b10; a_dest = 5'd10; step();
    idle(); a_v = 1'b1; a_kind = 2'b00; a_dest = 5'd11; step();
    idle(); c_v = 1'b1; c_tag = 3'((ta + 2) % DEPTH); c_val = 32'h22; step();
    idle(); c_v = 1'b1; c_tag = 3'((ta + 1) % DEPTH); c_mp = 1'b1; step();
    idle(); c_v = 1'b1; c_tag = 3'(ta); c_val = 32'h11; step();
    chk("R6 older register retires", 32'(reg_we_o), 32'd1);
    idle(); step();
    chk("R7 mispredict flush", 32'(flush_o), 32'd1);
    chk("R7 no write on flush", 32'(reg_we_o), 32'd0);
    idle(); a_v = 1'b1; c_v = 1'b1; c_tag = 3'((ta + 2) % DEPTH); rd_tag = 3'((ta + 2) % DEPTH);
    step();
    chk("R10 allocation in flush cycle ignored", 32'(alloc_tag_o), 32'd0);
    chk("R7 younger entry discarded", 32'(rd_ready_o), 32'd0);

    // R8 exception raised only at head
    idle(); a_v = 1'b1; a_dest = 5'd3; step();
    idle(); a_v = 1'b1; a_dest = 5'd4; step();
    idle(); c_v = 1'b1; c_tag = 3'd1; c_ex = 1'b1; step();
    chk("R8 no early exception", 32'(flush_o), 32'd0);
    chk("R8 no early excp flag", 32'(excp_o), 32'd0);
    idle(); c_v = 1'b1; c_tag = 3'd0; c_val = 32'h33; step();
    chk("R8 older entry retires first", 32'(retire_o), 32'd1);
    idle(); step();
    chk("R8 exception flush", 32'(flush_o), 32'd1);
    chk("R8 exception flag", 32'(excp_o), 32'd1);
    chk("R8 no write on exception", 32'(reg_we_o), 32'd0);
    idle(); step();

    // R9 mispredict on register entry ignored; R1 alloc with commit
    idle(); a_v = 1'b1; a_dest = 5'd7; step();
    idle(); c_v = 1'b1; c_tag = 3'd0; c_mp = 1'b1; c_val = 32'h55; step();
    chk("R9 register entry retires", 32'(retire_o), 32'd1);
    chk("R9 no flush", 32'(flush_o), 32'd0);
    idle(); a_v = 1'b1; a_dest = 5'd8; step();
    chk("R1 allocation during commit", 32'(alloc_tag_o), 32'd2);
    drain();

    // random traffic against the model
    repeat (400) begin
      idle();
      a_v = 1'($urandom); a_kind = 2'($urandom); a_dest = 5'($urandom);
      if ($urandom % 10 < 8) begin
        c_v = 1'b1;
        if (q.size() > 0 && $urandom % 4 != 0) c_tag = 3'(q[$urandom % q.size()].tag);
        else c_tag = 3'($urandom);
        c_val = $urandom;
        c_mp = ($urandom % 5 == 0);
        c_ex = ($urandom % 30 == 0);
      end
      rd_tag = 3'($urandom);
      step();
    end
    drain();
    finish_run();
  end
endmodule